// File: doc/BRIEF.md
# Register-Pointer Serial Slave (I2C / SMBus)

This block is the target-side controller of a two-wire serial bus for a bank of 16-bit registers. The SCL and SDA levels arrive as plain inputs and are resynchronised to the system clock. The block pulls SDA low through a single output enable. A transaction with the write direction bit first loads an 8-bit register pointer, which the block keeps. Two optional data bytes follow, high byte first, and the block hands them to the register file as one write strobe. A transaction with the read direction bit returns the addressed register, high byte first. The read value comes from the register file's read-data input or from the block's own identification constants.

The 7-bit device address is formed from a five-bit base parameter in the upper bits and the two address-select pins in the lower bits. The pins are sampled again at every address byte. The block also handles three bus features. It recognises the high-speed controller code and raises a mode flag without acknowledging. It answers the alert-response address while an alert is pending, and it backs off when it loses arbitration. It drops back to idle when the bus stalls in the middle of a transaction for longer than a programmable number of clock cycles (28 ms of wall time in the intended use).

Top module: `i2cr_slave`

## Requirements
- R1: The device address is {ADDR_BASE[4:0], addr_sel[1:0]}, sampled at each address byte. A matching address byte is acknowledged (SDA held low during the ninth clock). A byte matching no recognised address is not acknowledged, and SDA stays released until the next start or stop.
- R2: In a write transaction, the block acknowledges the pointer byte and then two data bytes, high byte first. After the eighth bit of the second data byte it gives one wr_en pulse, with reg_addr equal to the pointer and wr_data equal to {high byte, low byte}. Any further byte in the same transaction is not acknowledged.
- R3: A write transaction that carries only the pointer byte sets reg_addr. The pointer keeps its value across any number of reads until a later write transaction changes it.
- R4: A read transaction returns the high byte of the addressed register and then, if the controller acknowledges it, the low byte. rd_en pulses once, at the acknowledge of the read address.
- R5: After the controller answers a returned byte with a not-acknowledge, or after the low byte, the block leaves SDA released (reads as all ones) until the next start or stop.
- R6: Writes to any pointer other than 00h, 05h, 06h and 07h are still acknowledged in full, but no wr_en pulse is produced.
- R7: Pointer FEh reads 16'h5449 and pointer FFh reads 16'h2260. Pointers 00h–07h read rd_data. Every other pointer reads 16'h0000.
- R8: A first byte after a start whose upper five bits are 00001 is not acknowledged and sets hs_mode. A repeated start keeps hs_mode set. A stop clears it.
- R9: A read to address 0001100 is acknowledged only while alert_i is high. The block then returns one byte holding its own 7-bit address in bits 7:1, with bit 0 equal to 0.
- R10: While returning any byte, if the block sees SDA low at a rising SCL for a bit it left released, it stops driving SDA for the rest of the transaction.
- R11: If no SCL edge occurs for TIMEOUT_CYCLES clock cycles while a transaction is open, the block releases SDA and returns to idle. Bytes clocked afterwards without a new start are ignored.
- R12: sda_oe only turns on while the synchronised SCL is low. A start condition at any point restarts the address phase.
- R13: After reset, sda_oe, hs_mode, wr_en and rd_en are 0 and reg_addr is 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Level of the serial clock line |
| sda_i | input | 1 | Level of the serial data line |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| addr_sel | input | 2 | Low two bits of the device address |
| alert_i | input | 1 | Alert pending; enables the alert-response reply |
| hs_mode | output | 1 | High-speed mode flag |
| reg_addr | output | 8 | Retained register pointer |
| wr_en | output | 1 | One-cycle write strobe to the register file |
| wr_data | output | 16 | Data for the write strobe |
| rd_en | output | 1 | One-cycle strobe when the read value is captured |
| rd_data | input | 16 | Register file read data for reg_addr |

## Verification
Several properties are checked on every clock cycle: SDA is only pulled low while SCL is low, the two strobes never coincide, a stop always clears the high-speed flag, a write strobe only reaches a writable pointer, and an expired timeout always leaves the bus released and the block idle. Whether the right bytes come back, the pointer is retained, the alert reply carries the right address, arbitration loss stops the driver, and extra or misaddressed bytes go unacknowledged can only be shown by the bench's bus transactions, which compare every strobe and returned byte against a scoreboard.

// File: rtl/i2cr_pkg.sv
`timescale 1ns/1ps
package i2cr_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int CNT_W  = 4;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W + 1);
    localparam logic [6:0] ARA_ADDR  = 7'b0001100;
    localparam logic [4:0] HS_PREFIX = 5'b00001;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_PTR, ST_WMSB, ST_WLSB,
        ST_RDM, ST_RDL, ST_ARA, ST_DONE
    } slv_st_e;

    typedef struct packed {
        slv_st_e           st;
        slv_st_e           nst;
        logic [BYTE_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic              oe;
        logic [BYTE_W-1:0] tx;
        logic [BYTE_W-1:0] lsb;
        logic [BYTE_W-1:0] ptr;
        logic [WORD_W-1:0] wdat;
        logic              hs;
        logic              mack;
        logic              wr;
    } slv_t;
endpackage

// File: rtl/i2cr_sync.sv
`timescale 1ns/1ps
module i2cr_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] pipe_q [STAGES+1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i <= STAGES; i++) pipe_q[i] <= '1;
        end else begin
            pipe_q[0] <= raw_i;
            for (int i = 1; i <= STAGES; i++) pipe_q[i] <= pipe_q[i-1];
        end
    end

    assign lvl_o  = pipe_q[STAGES-1];
    assign prev_o = pipe_q[STAGES];
endmodule

// File: rtl/i2cr_timeout.sv
`timescale 1ns/1ps
module i2cr_timeout #(
    parameter int LIMIT = 2800000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic kick,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] TOP = CW'(LIMIT);
    localparam logic [CW-1:0] PRE = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!active || kick)  cnt_d = '0;
        else if (cnt_q != TOP) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = active && !kick && (cnt_q == PRE);

    // R11: once the window expires the controller must leave the open transaction
    a_r11_expire_drops_active: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> !active);
    a_r11_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TOP);
endmodule

// File: rtl/i2cr_regmap.sv
`timescale 1ns/1ps
module i2cr_regmap #(
    parameter int          PTR_W    = 8,
    parameter int          DATA_W   = 16,
    parameter int          LOCAL_N  = 8,
    parameter int          RO_FIRST = 1,
    parameter int          RO_LAST  = 4,
    parameter logic [15:0] ID_A     = 16'h5449,
    parameter logic [15:0] ID_B     = 16'h2260
) (
    input  logic [PTR_W-1:0]  ptr,
    input  logic [DATA_W-1:0] ext_rdata,
    output logic              writable,
    output logic [DATA_W-1:0] rd_value
);
    localparam logic [PTR_W-1:0] PTR_ID_A = {{(PTR_W-1){1'b1}}, 1'b0};
    localparam logic [PTR_W-1:0] PTR_ID_B = {PTR_W{1'b1}};

    logic in_local, in_ro;

    always_comb begin
        in_local = (int'(ptr) < LOCAL_N);
        in_ro    = (int'(ptr) >= RO_FIRST) && (int'(ptr) <= RO_LAST);
        writable = in_local && !in_ro;
        if (in_local)              rd_value = ext_rdata;
        else if (ptr == PTR_ID_A)  rd_value = DATA_W'(ID_A);
        else if (ptr == PTR_ID_B)  rd_value = DATA_W'(ID_B);
        else                       rd_value = '0;
    end
endmodule

// File: rtl/i2cr_slave.sv
`timescale 1ns/1ps
module i2cr_slave
    import i2cr_pkg::*;
#(
    parameter logic [4:0]  ADDR_BASE      = 5'b10000,
    parameter int          TIMEOUT_CYCLES = 2800000,
    parameter int          SYNC_STAGES    = 2,
    parameter logic [15:0] MFR_ID         = 16'h5449,
    parameter logic [15:0] DIE_ID         = 16'h2260
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe,
    input  logic [1:0]  addr_sel,
    input  logic        alert_i,
    output logic        hs_mode,
    output logic [7:0]  reg_addr,
    output logic        wr_en,
    output logic [15:0] wr_data,
    output logic        rd_en,
    input  logic [15:0] rd_data
);
    slv_t state_d, state_q;

    logic [1:0] bus_lvl, bus_prev;
    logic scl_lvl, sda_lvl, scl_rise, scl_fall;
    logic bus_start, bus_stop, tmo_hit, tx_st, rd_cap;
    logic writable;
    logic [WORD_W-1:0] rd_value;
    logic [6:0] own_addr;

    i2cr_sync #(.W(2), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .raw_i({scl_i, sda_i}),
        .lvl_o(bus_lvl), .prev_o(bus_prev)
    );

    assign scl_lvl   = bus_lvl[1];
    assign sda_lvl   = bus_lvl[0];
    assign scl_rise  = bus_lvl[1] & ~bus_prev[1];
    assign scl_fall  = ~bus_lvl[1] & bus_prev[1];
    assign bus_start = bus_lvl[1] & bus_prev[1] & bus_prev[0] & ~bus_lvl[0];
    assign bus_stop  = bus_lvl[1] & bus_prev[1] & ~bus_prev[0] & bus_lvl[0];
    assign own_addr  = {ADDR_BASE, addr_sel};
    assign tx_st     = (state_q.st == ST_RDM) || (state_q.st == ST_RDL) ||
                       (state_q.st == ST_ARA);

    i2cr_timeout #(.LIMIT(TIMEOUT_CYCLES)) tmo_i (
        .clk(clk), .rst_n(rst_n),
        .active(state_q.st != ST_IDLE),
        .kick(scl_rise | scl_fall | bus_start | bus_stop),
        .expired(tmo_hit)
    );

    i2cr_regmap #(.PTR_W(BYTE_W), .DATA_W(WORD_W), .ID_A(MFR_ID), .ID_B(DIE_ID)) map_i (
        .ptr(state_q.ptr), .ext_rdata(rd_data),
        .writable(writable), .rd_value(rd_value)
    );

    always_comb begin
        state_d    = state_q;
        state_d.wr = 1'b0;
        rd_cap     = 1'b0;
        if (bus_start) begin
            state_d.st  = ST_ADDR;
            state_d.cnt = '0;
            state_d.oe  = 1'b0;
        end else if (bus_stop) begin
            state_d.st = ST_IDLE;
            state_d.oe = 1'b0;
            state_d.hs = 1'b0;
        end else if (tmo_hit) begin
            state_d.st = ST_IDLE;
            state_d.oe = 1'b0;
        end else if (state_q.st != ST_IDLE && state_q.st != ST_DONE) begin
            if (scl_rise) begin
                if (state_q.cnt < LAST_BIT) begin
                    state_d.cnt = state_q.cnt + 1'b1;
                    if (tx_st) begin
                        // released bit seen low: another target won the bus
                        if (state_q.sh[BYTE_W-1] && !sda_lvl) begin
                            state_d.st = ST_DONE;
                            state_d.oe = 1'b0;
                        end
                    end else begin
                        state_d.sh = {state_q.sh[BYTE_W-2:0], sda_lvl};
                    end
                end else if (state_q.cnt == LAST_BIT) begin
                    state_d.cnt  = ACK_BIT;
                    state_d.mack = !sda_lvl;
                end
            end else if (scl_fall) begin
                if (state_q.cnt == LAST_BIT) begin
                    if (tx_st) begin
                        state_d.oe = 1'b0;
                    end else begin
                        state_d.nst = ST_DONE;
                        state_d.oe  = 1'b1;
                        unique case (state_q.st)
                            ST_ADDR: begin
                                if (state_q.sh[7:3] == HS_PREFIX) begin
                                    state_d.hs = 1'b1;
                                    state_d.oe = 1'b0;
                                end else if (state_q.sh[7:1] == own_addr) begin
                                    if (state_q.sh[0]) begin
                                        rd_cap        = 1'b1;
                                        state_d.nst   = ST_RDM;
                                        state_d.tx    = rd_value[WORD_W-1:BYTE_W];
                                        state_d.lsb   = rd_value[BYTE_W-1:0];
                                    end else begin
                                        state_d.nst = ST_PTR;
                                    end
                                end else if (state_q.sh == {ARA_ADDR, 1'b1} && alert_i) begin
                                    state_d.nst = ST_ARA;
                                    state_d.tx  = {own_addr, 1'b0};
                                end else begin
                                    state_d.oe = 1'b0;
                                end
                            end
                            ST_PTR: begin
                                state_d.ptr = state_q.sh;
                                state_d.nst = ST_WMSB;
                            end
                            ST_WMSB: begin
                                state_d.wdat[WORD_W-1:BYTE_W] = state_q.sh;
                                state_d.nst = ST_WLSB;
                            end
                            ST_WLSB: begin
                                state_d.wdat[BYTE_W-1:0] = state_q.sh;
                                state_d.wr = writable;
                            end
                            default: state_d.oe = 1'b0;
                        endcase
                    end
                end else if (state_q.cnt == ACK_BIT) begin
                    state_d.cnt = '0;
                    state_d.oe  = 1'b0;
                    state_d.st  = state_q.nst;
                    if (tx_st) begin
                        if (state_q.st == ST_RDM && state_q.mack) begin
                            state_d.st = ST_RDL;
                            state_d.sh = state_q.lsb;
                            state_d.oe = !state_q.lsb[BYTE_W-1];
                        end else begin
                            state_d.st = ST_DONE;
                        end
                    end else if (state_q.nst == ST_RDM || state_q.nst == ST_ARA) begin
                        state_d.sh = state_q.tx;
                        state_d.oe = !state_q.tx[BYTE_W-1];
                    end
                end else if (tx_st && state_q.cnt != '0) begin
                    state_d.sh = {state_q.sh[BYTE_W-2:0], 1'b0};
                    state_d.oe = !state_q.sh[BYTE_W-2];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= '0;
            state_q.st  <= ST_IDLE;
            state_q.nst <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign sda_oe   = state_q.oe;
    assign hs_mode  = state_q.hs;
    assign reg_addr = state_q.ptr;
    assign wr_en    = state_q.wr;
    assign wr_data  = state_q.wdat;
    assign rd_en    = rd_cap;

    a_r12_drive_only_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_lvl);
    a_r8_stop_clears_hs: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> !hs_mode);
    a_r11_timeout_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_hit && !bus_start && !bus_stop) |=> (!sda_oe && state_q.st == ST_IDLE));
    a_r2_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, rd_en}));
    a_r6_write_target: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (reg_addr == 8'h00 || reg_addr == 8'h05 ||
                   reg_addr == 8'h06 || reg_addr == 8'h07));
    a_r5_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.st == ST_DONE) |-> !sda_oe);
endmodule

// File: tb/i2cr_slave_tb_top.sv
`timescale 1ns/1ps
module i2cr_slave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;
    localparam int TMO        = 3000;
    localparam int WD_CYCLES  = 150000;
    localparam logic [4:0] BASE = 5'b10000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda_low = 1'b0;
    logic [1:0] sel = 2'b01;
    logic alert = 1'b0;
    logic sda_oe, hs_mode, wr_en, rd_en, sda_bus;
    logic [7:0] reg_addr;
    logic [15:0] wr_data, rd_data;

    int n_chk = 0, n_fail = 0, sb_chk = 0, sb_fail = 0, rd_cnt = 0;

    typedef struct packed { logic [7:0] a; logic [15:0] d; } wr_item_t;
    wr_item_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_bus = ~(m_sda_low | sda_oe);
    // bench register file model: pointer p (0..7) holds {p, ~p}
    assign rd_data = (reg_addr < 8'd8) ? {reg_addr, ~reg_addr} : 16'hDEAD;

    i2cr_slave #(.ADDR_BASE(BASE), .TIMEOUT_CYCLES(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
        .addr_sel(sel), .alert_i(alert), .hs_mode(hs_mode), .reg_addr(reg_addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data)
    );

    // scoreboard monitor: every write strobe must match the oldest expected item
    always @(negedge clk) begin
        if (rst_n && rd_en) rd_cnt++;
        if (rst_n && wr_en) begin
            sb_chk++;
            if (exp_q.size() == 0) begin
                sb_fail++;
                $display("FAIL R6: actual write %02h=%04h expected no write", reg_addr, wr_data);
            end else begin
                wr_item_t e;
                e = exp_q.pop_front();
                if (e.a !== reg_addr || e.d !== wr_data) begin
                    sb_fail++;
                    $display("FAIL R2: actual %02h=%04h expected %02h=%04h",
                             reg_addr, wr_data, e.a, e.d);
                end
            end
        end
    end

    task automatic report(input int extra);
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_chk + sb_chk + extra, n_fail + sb_fail + extra);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        $display("FAIL watchdog: actual hung expected finished");
        report(1);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bit_w(input logic b);
        m_sda_low = ~b; wq(1); m_scl = 1'b1; wq(2); m_scl = 1'b0; wq(1);
    endtask

    task automatic bit_r(output logic b);
        m_sda_low = 1'b0; wq(1); m_scl = 1'b1; wq(1); b = sda_bus; wq(1); m_scl = 1'b0; wq(1);
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0; wq(1); m_scl = 1'b1; wq(2); m_sda_low = 1'b1; wq(2); m_scl = 1'b0; wq(1);
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; wq(1); m_scl = 1'b1; wq(2); m_sda_low = 1'b0; wq(2);
    endtask

    task automatic wbyte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) bit_w(v[i]);
        bit_r(b);
        ack = ~b;
    endtask

    task automatic rbyte(output logic [7:0] v, input logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin bit_r(b); v[i] = b; end
        bit_w(~ack);
    endtask

    function automatic logic [7:0] own(input logic rd);
        return {BASE, sel, rd};
    endfunction

    task automatic wr_reg(input logic [7:0] p, input logic [15:0] v, input logic exp_wr,
                          input string req);
        logic a;
        if (exp_wr) exp_q.push_back({p, v});
        bus_start();
        wbyte(own(1'b0), a); chk(req, a, 1);
        wbyte(p, a);         chk(req, a, 1);
        wbyte(v[15:8], a);   chk(req, a, 1);
        wbyte(v[7:0], a);    chk(req, a, 1);
        bus_stop();
    endtask

    task automatic set_ptr(input logic [7:0] p);
        logic a;
        bus_start();
        wbyte(own(1'b0), a); chk("R3", a, 1);
        wbyte(p, a);         chk("R3", a, 1);
        bus_stop();
    endtask

    task automatic rd_reg(output logic [15:0] v);
        logic a;
        logic [7:0] hi, lo;
        bus_start();
        wbyte(own(1'b1), a); chk("R4", a, 1);
        rbyte(hi, 1'b1);
        rbyte(lo, 1'b0);
        bus_stop();
        v = {hi, lo};
    endtask

    initial begin
        logic a;
        logic [7:0] bv;
        logic [15:0] v;
        int rd0;

        repeat (5) @(negedge clk);
        // R13: reset state
        chk("R13", {sda_oe, hs_mode, wr_en, rd_en}, 4'b0000);
        chk("R13", reg_addr, 8'h00);
        rst_n = 1'b1;
        wq(2);

        // R2: plain writes to writable registers
        wr_reg(8'h05, 16'h0A00, 1'b1, "R2");
        wr_reg(8'h00, 16'h4127, 1'b1, "R2");

        // R2: extra byte after the data word is not acknowledged
        exp_q.push_back({8'h07, 16'h1234});
        bus_start();
        wbyte(own(1'b0), a); chk("R2", a, 1);
        wbyte(8'h07, a);     chk("R2", a, 1);
        wbyte(8'h12, a);     chk("R2", a, 1);
        wbyte(8'h34, a);     chk("R2", a, 1);
        wbyte(8'h56, a);     chk("R2", a, 0);
        bus_stop();

        // R3 / R4: pointer-only write, then two reads without rewriting it
        set_ptr(8'h02);
        chk("R3", reg_addr, 8'h02);
        rd0 = rd_cnt;
        rd_reg(v); chk("R4", v, 16'h02FD);
        rd_reg(v); chk("R3", v, 16'h02FD);
        chk("R4", rd_cnt - rd0, 2);
        chk("R3", reg_addr, 8'h02);

        // R6: read-only and undefined pointers acked but never written
        wr_reg(8'h03, 16'hBEEF, 1'b0, "R6");
        wr_reg(8'h40, 16'hCAFE, 1'b0, "R6");
        chk("R6", reg_addr, 8'h40);

        // R7: identification constants and undefined pointers
        set_ptr(8'hFE); rd_reg(v); chk("R7", v, 16'h5449);
        set_ptr(8'hFF); rd_reg(v); chk("R7", v, 16'h2260);
        set_ptr(8'h40); rd_reg(v); chk("R7", v, 16'h0000);
        set_ptr(8'h07); rd_reg(v); chk("R7", v, 16'h07F8);

        // R5: after NACK the bus stays released
        bus_start();
        wbyte(own(1'b1), a); chk("R5", a, 1);
        rbyte(bv, 1'b0);     chk("R5", bv, 8'h07);
        rbyte(bv, 1'b0);     chk("R5", bv, 8'hFF);
        bus_stop();

        // R1: address pins re-sampled; old address no longer matches
        sel = 2'b10;
        wq(1);
        bus_start(); wbyte(8'h82, a); chk("R1", a, 0); bus_stop();
        bus_start(); wbyte(own(1'b0), a); chk("R1", a, 1); wbyte(8'h06, a); bus_stop();
        chk("R1", reg_addr, 8'h06);
        sel = 2'b01;
        wq(1);

        // R8: high-speed controller code
        bus_start();
        wbyte(8'h0B, a); chk("R8", a, 0);
        chk("R8", hs_mode, 1);
        bus_start();
        wbyte(own(1'b0), a); chk("R8", a, 1);
        wbyte(8'h05, a);     chk("R8", a, 1);
        chk("R8", hs_mode, 1);
        bus_stop();
        chk("R8", hs_mode, 0);

        // R9: alert response address
        bus_start(); wbyte(8'h19, a); chk("R9", a, 0); bus_stop();
        alert = 1'b1;
        bus_start();
        wbyte(8'h19, a); chk("R9", a, 1);
        rbyte(bv, 1'b0); chk("R9", bv, 8'h82);
        bus_stop();

        // R10: arbitration loss on the first (released) bit of the reply
        bus_start();
        wbyte(8'h19, a); chk("R10", a, 1);
        bit_w(1'b0);
        for (int i = 6; i >= 0; i--) begin bit_r(a); bv[i] = a; end
        chk("R10", bv[6:0], 7'h7F);
        chk("R10", sda_oe, 0);
        bit_w(1'b1);
        bus_stop();
        alert = 1'b0;

        // R11: bus stalled while the target holds the acknowledge
        bus_start();
        for (int i = 7; i >= 0; i--) bit_w(own(1'b0) >> i);
        chk("R12", sda_oe, 1);
        repeat (TMO + 20) @(negedge clk);
        chk("R11", sda_oe, 0);
        bit_r(a);
        wbyte(8'h05, a); chk("R11", a, 0);
        bus_stop();

        // R12: a start mid-byte restarts the address phase
        bus_start();
        bit_w(1'b1); bit_w(1'b0); bit_w(1'b1);
        bus_start();
        wbyte(own(1'b0), a); chk("R12", a, 1);
        wbyte(8'h00, a);     chk("R12", a, 1);
        bus_stop();
        chk("R12", reg_addr, 8'h00);

        wq(4);
        chk("R2", exp_q.size(), 0);
        report(0);
        $finish;
    end
endmodule